// File: doc/BRIEF.md
# Pixel Gain, Look-Up and Output Packing Stage

This block sits in a camera image path between the sensor interface and the transport. It takes a stream of 10-bit pixels, each qualified by a valid strobe and tagged with start-of-frame and start-of-line markers. Each pixel goes through three registered steps:
- a saturating unsigned fixed-point digital gain;
- an optional remap through a programmable 1024-entry, 10-bit table;
- a packing step that places the value into a 16-bit output word in one of several layouts, or replaces it with a ramp test pattern.

A small register port configures the stage. It holds a control word (format code and table enable), the gain, and a table address. The fourth register is a table data window. Every access to the data window uses the current table address and then advances it by one, so the host can fill the table with a burst of data writes. Register reads are combinational on `reg_rdata`. A write or read strobe acts at the next rising clock edge.

Register map (`reg_addr`):
- 0: control. Bits [3:0] hold the format code and bit 4 enables the table.
- 1: gain.
- 2: table address.
- 3: table data window.

Top module: `pix_fmt_top`

## Requirements
- R1: The gained value is floor(pixel × gain / 16), where gain is the 8-bit register at address 1 in unsigned 4.4 format. Gain 0x10 is unity and gain 0 gives zero.
- R2: A gained value above 1023 is clamped to 1023; 1022 and below pass unchanged.
- R3: When control bit 4 is 1, the gained value is replaced by the table entry it indexes. When the bit is 0, the table contents have no effect on the output.
- R4: A write or read at address 3 uses the current table address. At the next edge it increments that address by one, and the address wraps from 1023 to 0. A write at address 2 loads the address. A read at address 3 returns the entry at the current address.
- R5: Format code 0000 puts the upper 8 bits of the 10-bit value in `out_data[7:0]`, with zeros above, and reports width 8.
- R6: Format code 0001 places the value in `out_data[15:6]`, zeros below, and reports width 16.
- R7: Format code 0010 places the value in `out_data[9:0]`, zeros above, with width 16. Code 1000 gives the same layout with width 10.
- R8: Format code 0100 outputs a ramp in `out_data[9:0]` with width 10. The ramp is 0 on a pixel marked start-of-line and otherwise one more than on the previous valid pixel. Pixel values are ignored.
- R9: `out_valid`, `out_sof` and `out_sol` follow `in_valid`, `in_valid & in_sof` and `in_valid & in_sol` exactly three clock edges later. The markers are never high without valid.
- R10: Any format code not listed above behaves like code 0000.
- R11: After reset, `out_valid` is 0, gain reads 0x10, and the control word and table address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | Start-of-frame marker on the pixel |
| in_sol | input | 1 | Start-of-line marker on the pixel |
| in_pix | input | 10 | Input pixel |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (advances the table address at address 3) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Delayed start-of-frame marker |
| out_sol | output | 1 | Delayed start-of-line marker |
| out_data | output | 16 | Packed output word |
| out_nbits | output | 5 | Meaningful bits in `out_data` for this format |

## Verification
The bench targets the following corner cases:
- **Clamp boundary.** It applies a product of exactly 1024 and one of 1022. A clamp with an off-by-one or wrong compare would pass 1024 through as 0 or clip the legal value.
- **Fractional gain.** It applies a gain below one. A design that rounds instead of truncating would return 2 where 1 is expected.
- **Table address.** It checks address wrap at 1023 and the increment on reads as well as writes. A design that advanced only on writes, or overflowed into an eleventh bit, would return the wrong entries on later accesses.
- **Ramp and latency.** It streams pixels with idle gaps and a mid-stream line start. This shows a ramp that counts idle cycles or ignores the line marker, and any pipeline that is one cycle short or long.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;

    // Register select codes
    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_GAIN = 2'd1,
        RA_LADR = 2'd2,
        RA_LDAT = 2'd3
    } ra_e;

    // Output format codes; the packing stage decodes these bit patterns
    typedef enum logic [3:0] {
        FMT_BYTE = 4'b0000,
        FMT_HI   = 4'b0001,
        FMT_LO   = 4'b0010,
        FMT_RAMP = 4'b0100,
        FMT_RAW  = 4'b1000
    } fmt_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/pfmt_regs.sv
module pfmt_regs
    import pfmt_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int GAIN_W   = 8,
    parameter int DATA_W   = 16,
    parameter int GAIN_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [PIX_W-1:0]  lut_addr,
    input  logic [PIX_W-1:0]  lut_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [3:0]        fmt,
    output logic              lut_en,
    output logic [GAIN_W-1:0] gain
);

    typedef struct packed {
        logic [3:0]        fmt;
        logic              lut_en;
        logic [GAIN_W-1:0] gain;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we && reg_addr == RA_CTRL) begin
            cfg_d.fmt    = reg_wdata[3:0];
            cfg_d.lut_en = reg_wdata[4];
        end
        if (reg_we && reg_addr == RA_GAIN) begin
            cfg_d.gain = reg_wdata[GAIN_W-1:0];
        end
        unique case (reg_addr)
            RA_CTRL: reg_rdata = DATA_W'({cfg_q.lut_en, cfg_q.fmt});
            RA_GAIN: reg_rdata = DATA_W'(cfg_q.gain);
            RA_LADR: reg_rdata = DATA_W'(lut_addr);
            default: reg_rdata = DATA_W'(lut_rd);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{fmt: 4'b0000, lut_en: 1'b0, gain: GAIN_W'(GAIN_RST)};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fmt    = cfg_q.fmt;
    assign lut_en = cfg_q.lut_en;
    assign gain   = cfg_q.gain;

endmodule

// File: rtl/pfmt_gain.sv
module pfmt_gain #(
    parameter int PIX_W  = 10,
    parameter int GAIN_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [GAIN_W-1:0] gain,
    output logic              s1_valid,
    output logic              s1_sof,
    output logic              s1_sol,
    output logic [PIX_W-1:0]  s1_pix,
    output logic [PIX_W-1:0]  s1_ramp
);

    localparam int PROD_W = PIX_W + GAIN_W;
    localparam logic [PROD_W-1:0] SAT = PROD_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic             valid;
        logic             sof;
        logic             sol;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] ramp;
        logic [PIX_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [PIX_W-1:0]  ramp_now;

    always_comb begin
        prod     = PROD_W'(in_pix) * PROD_W'(gain);
        scaled   = prod >> FRAC_W;
        ramp_now = in_sol ? '0 : st_q.cnt;
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.sof   = in_valid & in_sof;
        st_d.sol   = in_valid & in_sol;
        if (in_valid) begin
            st_d.pix  = (scaled > SAT) ? PIX_W'(SAT) : scaled[PIX_W-1:0];
            st_d.ramp = ramp_now;
            st_d.cnt  = ramp_now + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_valid = st_q.valid;
    assign s1_sof   = st_q.sof;
    assign s1_sol   = st_q.sol;
    assign s1_pix   = st_q.pix;
    assign s1_ramp  = st_q.ramp;

endmodule

// File: rtl/pfmt_lut.sv
module pfmt_lut
    import pfmt_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              lut_en,
    input  logic              s1_valid,
    input  logic              s1_sof,
    input  logic              s1_sol,
    input  logic [PIX_W-1:0]  s1_pix,
    input  logic [PIX_W-1:0]  s1_ramp,
    output logic              s2_valid,
    output logic              s2_sof,
    output logic              s2_sol,
    output logic [PIX_W-1:0]  s2_pix,
    output logic [PIX_W-1:0]  s2_ramp,
    output logic [PIX_W-1:0]  lut_addr,
    output logic [PIX_W-1:0]  lut_rd
);

    localparam int DEPTH = 1 << PIX_W;

    typedef struct packed {
        logic             valid;
        logic             sof;
        logic             sol;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] ramp;
        logic [PIX_W-1:0] addr;
    } st_t;

    st_t st_d, st_q;
    logic [PIX_W-1:0] mem [DEPTH];
    logic             addr_load;
    logic             data_acc;
    logic             data_wr;

    always_comb begin
        addr_load = reg_we && (reg_addr == RA_LADR);
        data_acc  = (reg_we || reg_re) && (reg_addr == RA_LDAT);
        data_wr   = reg_we && (reg_addr == RA_LDAT);
        st_d       = st_q;
        st_d.valid = s1_valid;
        st_d.sof   = s1_sof;
        st_d.sol   = s1_sol;
        st_d.ramp  = s1_ramp;
        st_d.pix   = lut_en ? mem[s1_pix] : s1_pix;
        if (addr_load) begin
            st_d.addr = reg_wdata[PIX_W-1:0];
        end else if (data_acc) begin
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (data_wr) begin
            mem[st_q.addr] <= reg_wdata[PIX_W-1:0];
        end
    end

    assign s2_valid = st_q.valid;
    assign s2_sof   = st_q.sof;
    assign s2_sol   = st_q.sol;
    assign s2_pix   = st_q.pix;
    assign s2_ramp  = st_q.ramp;
    assign lut_addr = st_q.addr;
    assign lut_rd   = mem[st_q.addr];

endmodule

// File: rtl/pfmt_pack.sv
module pfmt_pack
    import pfmt_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int OUT_W = 16,
    parameter int NB_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       fmt,
    input  logic             s2_valid,
    input  logic             s2_sof,
    input  logic             s2_sol,
    input  logic [PIX_W-1:0] s2_pix,
    input  logic [PIX_W-1:0] s2_ramp,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_sol,
    output logic [OUT_W-1:0] out_data,
    output logic [NB_W-1:0]  out_nbits
);

    typedef struct packed {
        logic             valid;
        logic             sof;
        logic             sol;
        logic [OUT_W-1:0] data;
        logic [NB_W-1:0]  nbits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.valid = s2_valid;
        st_d.sof   = s2_sof;
        st_d.sol   = s2_sol;
        if (s2_valid) begin
            case (fmt)
                FMT_HI: begin
                    st_d.data  = OUT_W'(s2_pix) << (OUT_W - PIX_W);
                    st_d.nbits = NB_W'(OUT_W);
                end
                FMT_LO: begin
                    st_d.data  = OUT_W'(s2_pix);
                    st_d.nbits = NB_W'(OUT_W);
                end
                FMT_RAW: begin
                    st_d.data  = OUT_W'(s2_pix);
                    st_d.nbits = NB_W'(PIX_W);
                end
                FMT_RAMP: begin
                    st_d.data  = OUT_W'(s2_ramp);
                    st_d.nbits = NB_W'(PIX_W);
                end
                default: begin
                    st_d.data  = OUT_W'(s2_pix >> (PIX_W - BYTE_W));
                    st_d.nbits = NB_W'(BYTE_W);
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_sof   = st_q.sof;
    assign out_sol   = st_q.sol;
    assign out_data  = st_q.data;
    assign out_nbits = st_q.nbits;

endmodule

// File: rtl/pix_fmt_top.sv
module pix_fmt_top #(
    parameter int PIX_W  = 10,
    parameter int GAIN_W = 8,
    parameter int FRAC_W = 4,
    parameter int DATA_W = 16,
    parameter int OUT_W  = 16,
    localparam int NB_W  = $clog2(OUT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_sol,
    output logic [OUT_W-1:0]  out_data,
    output logic [NB_W-1:0]   out_nbits
);

    localparam int GAIN_RST = 1 << FRAC_W;

    logic [3:0]        fmt;
    logic              lut_en;
    logic [GAIN_W-1:0] gain;
    logic [PIX_W-1:0]  lut_addr_w;
    logic [PIX_W-1:0]  lut_rd_w;
    logic              s1_valid, s1_sof, s1_sol;
    logic [PIX_W-1:0]  s1_pix, s1_ramp;
    logic              s2_valid, s2_sof, s2_sol;
    logic [PIX_W-1:0]  s2_pix, s2_ramp;

    pfmt_regs #(
        .PIX_W(PIX_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W), .GAIN_RST(GAIN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .lut_addr(lut_addr_w), .lut_rd(lut_rd_w),
        .reg_rdata(reg_rdata), .fmt(fmt), .lut_en(lut_en), .gain(gain)
    );

    pfmt_gain #(
        .PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)
    ) u_gain (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_pix(in_pix), .gain(gain),
        .s1_valid(s1_valid), .s1_sof(s1_sof), .s1_sol(s1_sol),
        .s1_pix(s1_pix), .s1_ramp(s1_ramp)
    );

    pfmt_lut #(
        .PIX_W(PIX_W), .DATA_W(DATA_W)
    ) u_lut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .lut_en(lut_en),
        .s1_valid(s1_valid), .s1_sof(s1_sof), .s1_sol(s1_sol),
        .s1_pix(s1_pix), .s1_ramp(s1_ramp),
        .s2_valid(s2_valid), .s2_sof(s2_sof), .s2_sol(s2_sol),
        .s2_pix(s2_pix), .s2_ramp(s2_ramp),
        .lut_addr(lut_addr_w), .lut_rd(lut_rd_w)
    );

    pfmt_pack #(
        .PIX_W(PIX_W), .OUT_W(OUT_W), .NB_W(NB_W)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .fmt(fmt),
        .s2_valid(s2_valid), .s2_sof(s2_sof), .s2_sol(s2_sol),
        .s2_pix(s2_pix), .s2_ramp(s2_ramp),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_data(out_data), .out_nbits(out_nbits)
    );

endmodule

// File: rtl/pfmt_chk.sv
module pfmt_chk #(
    parameter int PIX_W  = 10,
    parameter int OUT_W  = 16,
    parameter int NB_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             reg_we,
    input logic             reg_re,
    input logic [1:0]       reg_addr,
    input logic [PIX_W-1:0] lut_addr,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_sol,
    input logic [OUT_W-1:0] out_data,
    input logic [NB_W-1:0]  out_nbits
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R9
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R11
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd3) |-> !out_valid);

    // R9
    marker_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_sof && !out_sol));

    // R5
    byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nbits == NB_W'(8)) |-> (out_data[OUT_W-1:8] == '0));

    // R7
    ten_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nbits == NB_W'(PIX_W)) |-> (out_data[OUT_W-1:PIX_W] == '0));

    // R4
    lut_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_we || reg_re) && reg_addr == 2'd3) |=>
        (lut_addr == PIX_W'($past(lut_addr) + 1'b1)));

endmodule

bind pix_fmt_top pfmt_chk #(
    .PIX_W(PIX_W), .OUT_W(OUT_W), .NB_W(NB_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .lut_addr(lut_addr_w),
    .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
    .out_data(out_data), .out_nbits(out_nbits)
);

// File: tb/tb_pix_fmt_top.sv
`timescale 1ns/1ps
module tb_pix_fmt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [9:0]  in_pix = '0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        out_valid, out_sof, out_sol;
    logic [15:0] out_data;
    logic [4:0]  out_nbits;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pix_fmt_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_pix(in_pix), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_data(out_data), .out_nbits(out_nbits)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  fmt;
        logic        lut;
        logic [7:0]  gain;
        logic [9:0]  pix;
        logic [15:0] exp;
        logic [4:0]  nb;
    } vec_t;

    // table entries are loaded as 1023 - index
    localparam vec_t VEC [15] = '{
        '{4'd1,  4'h2, 1'b0, 8'h10, 10'd300,  16'h012C, 5'd16}, // R1 unity
        '{4'd1,  4'h2, 1'b0, 8'h18, 10'd100,  16'h0096, 5'd16}, // R1 1.5x
        '{4'd1,  4'h2, 1'b0, 8'h08, 10'd3,    16'h0001, 5'd16}, // R1 truncation
        '{4'd2,  4'h2, 1'b0, 8'hFF, 10'd1023, 16'h03FF, 5'd16}, // R2 max gain
        '{4'd2,  4'h2, 1'b0, 8'h20, 10'd512,  16'h03FF, 5'd16}, // R2 product 1024
        '{4'd2,  4'h2, 1'b0, 8'h20, 10'd511,  16'h03FE, 5'd16}, // R2 product 1022
        '{4'd3,  4'h2, 1'b1, 8'h10, 10'd0,    16'h03FF, 5'd16}, // R3 entry 0
        '{4'd3,  4'h2, 1'b1, 8'h10, 10'd1000, 16'h0017, 5'd16}, // R3 entry 1000
        '{4'd5,  4'h0, 1'b0, 8'h10, 10'h3FF,  16'h00FF, 5'd8},  // R5 full scale
        '{4'd5,  4'h0, 1'b0, 8'h10, 10'h203,  16'h0080, 5'd8},  // R5 low bits dropped
        '{4'd6,  4'h1, 1'b0, 8'h10, 10'h2A5,  16'hA940, 5'd16}, // R6
        '{4'd7,  4'h8, 1'b0, 8'h10, 10'h155,  16'h0155, 5'd10}, // R7 raw
        '{4'd6,  4'h1, 1'b1, 8'h10, 10'd5,    16'hFE80, 5'd16}, // R6 with R3
        '{4'd10, 4'h3, 1'b0, 8'h10, 10'h3FF,  16'h00FF, 5'd8},  // R10 unlisted
        '{4'd1,  4'h0, 1'b1, 8'h00, 10'd700,  16'h00FF, 5'd8}   // R1 zero gain, R3
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, input logic strobe,
                          output logic [15:0] d);
        reg_re = strobe; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    // one pixel, then idle; returns just after the edge where it reaches the output
    task automatic send_px(input logic [9:0] p);
        in_valid = 1'b1; in_pix = p; in_sof = 1'b0; in_sol = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk); #1;
        chk(9, "valid one cycle early", {31'b0, out_valid}, 32'd0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(11, "out_valid after reset", {31'b0, out_valid}, 32'd0);
        reg_rd(2'd1, 1'b0, rd); chk(11, "gain reset", rd, 32'h10);
        reg_rd(2'd0, 1'b0, rd); chk(11, "ctrl reset", rd, 32'h0);
        reg_rd(2'd2, 1'b0, rd); chk(11, "lut addr reset", rd, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        reg_rd(2'd1, 1'b0, rd); chk(11, "gain after release", rd, 32'h10);

        // fill the table by successive data writes (R4)
        reg_wr(2'd2, 16'd0);
        for (int a = 0; a < 1024; a++) reg_wr(2'd3, 16'(1023 - a));
        reg_rd(2'd2, 1'b0, rd); chk(4, "addr after 1024 writes wraps", rd, 32'h0);

        // vector table
        for (int i = 0; i < 15; i++) begin
            reg_wr(2'd0, 16'({VEC[i].lut, VEC[i].fmt}));
            reg_wr(2'd1, 16'(VEC[i].gain));
            send_px(VEC[i].pix);
            chk(int'(VEC[i].req), $sformatf("vector %0d valid", i), {31'b0, out_valid}, 32'd1);
            chk(int'(VEC[i].req), $sformatf("vector %0d data", i), out_data, 32'(VEC[i].exp));
            chk(int'(VEC[i].req), $sformatf("vector %0d width", i), out_nbits, 32'(VEC[i].nb));
        end

        // R4 read path advances the address
        reg_wr(2'd2, 16'd5);
        reg_rd(2'd3, 1'b1, rd); chk(4, "read entry 5", rd, 32'd1018);
        reg_rd(2'd3, 1'b1, rd); chk(4, "read entry 6", rd, 32'd1017);
        reg_rd(2'd2, 1'b0, rd); chk(4, "addr after two reads", rd, 32'd7);

        // R4 wrap at the top entry
        reg_wr(2'd2, 16'd1023);
        reg_wr(2'd3, 16'h2AA);
        reg_rd(2'd2, 1'b0, rd); chk(4, "addr wrap on write", rd, 32'd0);
        reg_wr(2'd2, 16'd1023);
        reg_rd(2'd3, 1'b1, rd); chk(4, "entry 1023 readback", rd, 32'h2AA);
        reg_rd(2'd2, 1'b0, rd); chk(4, "addr wrap on read", rd, 32'd0);

        // R3 bypass: table full of non-identity data, enable off
        reg_wr(2'd0, 16'h02);
        reg_wr(2'd1, 16'h10);
        send_px(10'd1023);
        chk(3, "bypass ignores table", out_data, 32'h3FF);

        // R8 ramp stream with R9 latency and markers
        reg_wr(2'd0, 16'h04);
        begin
            logic sv [9] = '{1, 1, 1, 0, 1, 1, 1, 0, 0};
            logic sl [9] = '{1, 0, 0, 0, 0, 1, 0, 0, 0};
            logic sf [9] = '{1, 0, 0, 0, 0, 0, 0, 0, 0};
            logic [9:0] model_cnt = '0;
            logic [9:0] exp_r [9];
            for (int k = 0; k < 9; k++) begin
                exp_r[k] = sl[k] ? 10'd0 : model_cnt;
                if (sv[k]) model_cnt = exp_r[k] + 10'd1;
            end
            for (int i = 0; i < 11; i++) begin
                if (i < 9) begin
                    in_valid = sv[i]; in_sol = sl[i]; in_sof = sf[i];
                    in_pix = 10'(37 * i + 11);
                end else begin
                    in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
                end
                @(posedge clk); #1;
                if (i < 2) begin
                    chk(9, "no output before latency", {31'b0, out_valid}, 32'd0);
                end else begin
                    chk(9, $sformatf("stream %0d valid", i - 2), {31'b0, out_valid}, {31'b0, sv[i-2]});
                    chk(9, $sformatf("stream %0d sol", i - 2), {31'b0, out_sol}, {31'b0, sl[i-2]});
                    chk(9, $sformatf("stream %0d sof", i - 2), {31'b0, out_sof}, {31'b0, sf[i-2]});
                    if (sv[i-2]) begin
                        chk(8, $sformatf("ramp %0d", i - 2), out_data, 32'(exp_r[i-2]));
                        chk(8, $sformatf("ramp width %0d", i - 2), out_nbits, 32'd10);
                    end
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule